// File: doc/BRIEF.md
# Central Connection Scheduler with Code Keys

This block sets up and tears down point-to-point links between the nodes of a code-division interconnect. A node that wants to send raises its request line and places a destination index on its address field. The scheduler claims the destination's receive port, tells that receiver a sender is asking and who it is, and waits for the receiver to answer ready or busy. On a ready answer, the scheduler grants the sender and gives the same spreading-key index to both ends. On a busy answer, it refuses the sender. A receiver that is always able to take data can set its dedicated flag. The scheduler then grants without asking it, as long as the port is free. A link lasts as long as the sender holds its request and ends on the cycle after the request falls.

Key indices come from a shared pool. The lowest free index is handed out, and an index returns to the pool when its link ends. No data moves through this block, so every pin is a plain control or status level with no valid/ready pairing. Requests are levels: a sender keeps its request high until it is granted, refused or no longer interested. A receiver's ready and busy inputs are read only while its port is being asked.

Top module: `keysched_hub`

## Requirements
- R1: After reset, every grant, refuse, notify and link output is 0, every key and peer field is 0, and all key indices are free.
- R2: A request to a valid and unclaimed destination that wins arbitration raises rx_notify of that destination from the next cycle. rx_peer of that destination holds the requester index while the port is claimed. Destination fields are AW bits wide, and node n uses bits [n*AW +: AW].
- R3: When the receiver answers ready (rx_ack high), tx_grant of the sender rises exactly 3 clock edges after the first edge at which the request was sampled. The three edges are: inform, response, and grant with key.
- R4: A receiver answering busy (rx_busy high, rx_ack low) while notified makes tx_refuse of the sender high after the next edge and frees the port. If the sender holds its request, it is arbitrated again on every following cycle. If both rx_ack and rx_busy are high, the ready answer wins.
- R5: When rx_dedicated of the destination is set and the port is free, the receiver is not asked. tx_grant rises 2 edges after the request, whatever rx_ack and rx_busy are.
- R6: When a link is granted, tx_key of the sender and rx_key of the receiver carry the same index. It is the lowest free index, with simultaneous grants served from the lowest node index up. No two live links share an index, and an index is reusable after its link ends. Key fields are KW bits wide, and node n uses bits [n*KW +: KW].
- R7: When several senders request the same free port in one cycle, the lowest node index claims it. The others get neither a grant nor a refuse while the port is held.
- R8: When the request of a linked sender falls, tx_grant, rx_link and both key fields go to 0 after the next edge.
- R9: A request whose destination is the requester itself or an index of N or above is refused after the next edge.
- R10: A notified receiver that answers neither ready nor busy keeps the port claimed and notify high for as long as the sender holds its request. Dropping the request releases the port after the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scheduler clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_req | input | N | Per-node link request level |
| tx_dest | input | N*AW | Per-node destination index |
| rx_ack | input | N | Per-node receiver ready answer |
| rx_busy | input | N | Per-node receiver busy answer |
| rx_dedicated | input | N | Per-node flag: receiver always ready, skip asking |
| tx_grant | output | N | Sender holds a live link |
| tx_refuse | output | N | Sender's last attempt was refused |
| tx_key | output | N*KW | Key index of the sender's live link, else 0 |
| rx_notify | output | N | Receiver is being asked to accept a sender |
| rx_link | output | N | Receiver holds a live link |
| rx_peer | output | N*AW | Index of the sender that claimed this receiver port |
| rx_key | output | N*KW | Key index of the receiver's live link, else 0 |

## Verification
The bench checks grant timing to the exact edge on both the asked path and the dedicated path. A design that merged or added a stage would grant one cycle early or late. It checks key reuse after teardown, because a pool that leaked indices or handed out the same index twice would show the wrong or a duplicate key on a later grant. It races three senders onto one unanswered receiver and then withdraws the winner, so that priority that was not fixed, or a claim that was not released, would show up as the wrong peer or a stuck notify. A long random phase with self-addresses and out-of-range addresses is compared cycle by cycle against a behavioural model, which exposes any slip in the refusal and re-arbitration paths.

// File: rtl/ks_pkg.sv
package ks_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_ASK    = 3'd1,
    ST_RESP   = 3'd2,
    ST_LINK   = 3'd3,
    ST_REFUSE = 3'd4
  } lnk_st_t;
endpackage

// File: rtl/ks_prio.sv
// Fixed-priority pick: lowest set bit wins.
module ks_prio #(
  parameter int W = 6
) (
  input  logic [W-1:0] req_i,
  output logic [W-1:0] gnt_o
);
  logic seen;
  always_comb begin
    gnt_o = '0;
    seen  = 1'b0;
    for (int i = 0; i < W; i++) begin
      if (req_i[i] && !seen) begin
        gnt_o[i] = 1'b1;
        seen     = 1'b1;
      end
    end
  end
endmodule

// File: rtl/ks_keypool.sv
// Free pool of key indices; lowest free served first, in sender order.
module ks_keypool #(
  parameter int N  = 6,
  parameter int NK = 8,
  parameter int KW = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N-1:0]    alloc_i,
  input  logic [N-1:0]    rel_i,
  input  logic [N*KW-1:0] rel_key_i,
  output logic [N*KW-1:0] new_key_o
);
  logic [NK-1:0] free_q, avail, used, back;
  logic          hit;

  always_comb begin
    avail     = free_q;
    used      = '0;
    new_key_o = '0;
    hit       = 1'b0;
    for (int t = 0; t < N; t++) begin
      hit = 1'b0;
      if (alloc_i[t]) begin
        for (int k = 0; k < NK; k++) begin
          if (!hit && avail[k]) begin
            hit                   = 1'b1;
            avail[k]              = 1'b0;
            used[k]               = 1'b1;
            new_key_o[t*KW +: KW] = KW'(k);
          end
        end
      end
    end
  end

  always_comb begin
    back = '0;
    for (int t = 0; t < N; t++)
      if (rel_i[t]) back[rel_key_i[t*KW +: KW]] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) free_q <= '1;
    else        free_q <= (free_q & ~used) | back;
  end

  // R6: never allocate out of an empty pool
  p_pool_nonempty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|alloc_i) |-> (|free_q));
endmodule

// File: rtl/ks_node.sv
// Per-sender link state machine.
module ks_node
  import ks_pkg::*;
#(
  parameter int AW = 3,
  parameter int KW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_i,
  input  logic [AW-1:0] dest_i,
  input  logic          dest_ok_i,
  input  logic          win_i,
  input  logic          ded_i,
  input  logic          ack_i,
  input  logic          busy_i,
  input  logic [KW-1:0] key_i,
  output lnk_st_t       st_o,
  output logic [AW-1:0] dest_o,
  output logic [KW-1:0] key_o,
  output logic          want_o,
  output logic          alloc_o,
  output logic          rel_o
);
  lnk_st_t       st_q, st_d;
  logic [AW-1:0] dst_q;
  logic [KW-1:0] key_q;
  logic          idle_like;

  assign idle_like = (st_q == ST_IDLE) || (st_q == ST_REFUSE);
  assign want_o    = idle_like && req_i && dest_ok_i;
  assign alloc_o   = (st_q == ST_RESP) && req_i;
  assign rel_o     = (st_q == ST_LINK) && !req_i;
  assign st_o      = st_q;
  assign dest_o    = dst_q;
  assign key_o     = key_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE, ST_REFUSE: begin
        if (!req_i)          st_d = ST_IDLE;
        else if (!dest_ok_i) st_d = ST_REFUSE;
        else if (win_i)      st_d = ded_i ? ST_RESP : ST_ASK;
      end
      ST_ASK: begin
        if (!req_i)      st_d = ST_IDLE;
        else if (ack_i)  st_d = ST_RESP;
        else if (busy_i) st_d = ST_REFUSE;
      end
      ST_RESP: st_d = req_i ? ST_LINK : ST_IDLE;
      ST_LINK: if (!req_i) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      dst_q <= '0;
      key_q <= '0;
    end else begin
      st_q <= st_d;
      if (want_o && win_i) dst_q <= dest_i;
      if (alloc_o)         key_q <= key_i;
      else if (rel_o)      key_q <= '0;
    end
  end

  p_grant_from_resp_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_q == ST_LINK) |-> ($past(st_q) == ST_RESP));
  p_busy_refuses_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_ASK && req_i && !ack_i && busy_i) |=> (st_q == ST_REFUSE));
  p_dedicated_skip_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (want_o && win_i && ded_i) |=> (st_q == ST_RESP));
  p_drop_ends_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_IDLE && !req_i) |=> (st_q == ST_IDLE));
  p_bad_dest_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_like && req_i && !dest_ok_i) |=> (st_q == ST_REFUSE));
  p_wait_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_ASK && req_i && !ack_i && !busy_i) |=> (st_q == ST_ASK));
endmodule

// File: rtl/keysched_hub.sv
module keysched_hub
  import ks_pkg::*;
#(
  parameter int N     = 6,
  parameter int NKEYS = 8
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic [N-1:0]                           tx_req,
  input  logic [N*((N > 1) ? $clog2(N) : 1)-1:0] tx_dest,
  input  logic [N-1:0]                           rx_ack,
  input  logic [N-1:0]                           rx_busy,
  input  logic [N-1:0]                           rx_dedicated,
  output logic [N-1:0]                           tx_grant,
  output logic [N-1:0]                           tx_refuse,
  output logic [N*((NKEYS > 1) ? $clog2(NKEYS) : 1)-1:0] tx_key,
  output logic [N-1:0]                           rx_notify,
  output logic [N-1:0]                           rx_link,
  output logic [N*((N > 1) ? $clog2(N) : 1)-1:0] rx_peer,
  output logic [N*((NKEYS > 1) ? $clog2(NKEYS) : 1)-1:0] rx_key
);
  localparam int AW = (N > 1) ? $clog2(N) : 1;
  localparam int KW = (NKEYS > 1) ? $clog2(NKEYS) : 1;

  lnk_st_t       st   [N];
  logic [AW-1:0] din  [N];
  logic [AW-1:0] dq   [N];
  logic [KW-1:0] kq   [N];
  logic [N-1:0]  cand [N];
  logic [N-1:0]  pick [N];
  logic [N-1:0]  own  [N];
  logic [N-1:0]  want, win, alloc, rel, dest_ok, ded_sel, ack_sel, busy_sel, owned;
  logic [N*KW-1:0] new_key, rel_key;

  for (genvar g = 0; g < N; g++) begin : g_tx
    assign din[g]      = tx_dest[g*AW +: AW];
    assign dest_ok[g]  = (int'(din[g]) < N) && (int'(din[g]) != g);
    assign rel_key[g*KW +: KW] = kq[g];

    always_comb begin
      ded_sel[g]  = 1'b0;
      ack_sel[g]  = 1'b0;
      busy_sel[g] = 1'b0;
      for (int r = 0; r < N; r++) begin
        if (din[g] == AW'(r)) ded_sel[g] = rx_dedicated[r];
        if (dq[g] == AW'(r)) begin
          ack_sel[g]  = rx_ack[r];
          busy_sel[g] = rx_busy[r];
        end
      end
    end

    ks_node #(.AW(AW), .KW(KW)) u_node (
      .clk(clk), .rst_n(rst_n), .req_i(tx_req[g]), .dest_i(din[g]),
      .dest_ok_i(dest_ok[g]), .win_i(win[g]), .ded_i(ded_sel[g]),
      .ack_i(ack_sel[g]), .busy_i(busy_sel[g]), .key_i(new_key[g*KW +: KW]),
      .st_o(st[g]), .dest_o(dq[g]), .key_o(kq[g]), .want_o(want[g]),
      .alloc_o(alloc[g]), .rel_o(rel[g])
    );

    assign tx_grant[g]          = (st[g] == ST_LINK);
    assign tx_refuse[g]         = (st[g] == ST_REFUSE);
    assign tx_key[g*KW +: KW]   = (st[g] == ST_LINK) ? kq[g] : '0;
  end

  // Port ownership follows from sender state: claimed while asking, responding or linked.
  always_comb begin
    for (int r = 0; r < N; r++) begin
      for (int t = 0; t < N; t++)
        own[r][t] = (st[t] == ST_ASK || st[t] == ST_RESP || st[t] == ST_LINK) &&
                    (dq[t] == AW'(r));
      owned[r] = |own[r];
      for (int t = 0; t < N; t++)
        cand[r][t] = want[t] && (din[t] == AW'(r)) && !owned[r];
    end
  end

  for (genvar r = 0; r < N; r++) begin : g_rx
    ks_prio #(.W(N)) u_prio (.req_i(cand[r]), .gnt_o(pick[r]));
    p_single_owner_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(own[r]));
  end

  always_comb begin
    win = '0;
    for (int r = 0; r < N; r++) win = win | pick[r];
  end

  ks_keypool #(.N(N), .NK(NKEYS), .KW(KW)) u_pool (
    .clk(clk), .rst_n(rst_n), .alloc_i(alloc), .rel_i(rel),
    .rel_key_i(rel_key), .new_key_o(new_key)
  );

  always_comb begin
    rx_notify = '0;
    rx_link   = '0;
    rx_peer   = '0;
    rx_key    = '0;
    for (int r = 0; r < N; r++) begin
      for (int t = 0; t < N; t++) begin
        if (own[r][t]) begin
          rx_peer[r*AW +: AW] = AW'(t);
          if (st[t] == ST_ASK) rx_notify[r] = 1'b1;
          if (st[t] == ST_LINK) begin
            rx_link[r]          = 1'b1;
            rx_key[r*KW +: KW]  = kq[t];
          end
        end
      end
    end
  end

  for (genvar a = 0; a < N; a++) begin : g_ka
    for (genvar b = a + 1; b < N; b++) begin : g_kb
      p_key_unique_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st[a] == ST_LINK && st[b] == ST_LINK) |-> (kq[a] != kq[b]));
    end
  end
endmodule

// File: tb/sim_keysched_hub.sv
module sim_keysched_hub;
  localparam int N  = 6;
  localparam int NK = 8;
  localparam int AW = 3;
  localparam int KW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0]    tx_req = '0, rx_ack = '0, rx_busy = '0, rx_dedicated = '0;
  logic [N*AW-1:0] tx_dest = '0;
  logic [N-1:0]    tx_grant, tx_refuse, rx_notify, rx_link;
  logic [N*KW-1:0] tx_key, rx_key;
  logic [N*AW-1:0] rx_peer;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #2 clk = ~clk;

  keysched_hub #(.N(N), .NKEYS(NK)) u0 (
    .clk(clk), .rst_n(rst_n), .tx_req(tx_req), .tx_dest(tx_dest),
    .rx_ack(rx_ack), .rx_busy(rx_busy), .rx_dedicated(rx_dedicated),
    .tx_grant(tx_grant), .tx_refuse(tx_refuse), .tx_key(tx_key),
    .rx_notify(rx_notify), .rx_link(rx_link), .rx_peer(rx_peer), .rx_key(rx_key)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic int tk(input int n);  return int'(tx_key[n*KW +: KW]);  endfunction
  function automatic int rk(input int n);  return int'(rx_key[n*KW +: KW]);  endfunction
  function automatic int pr(input int n);  return int'(rx_peer[n*AW +: AW]); endfunction
  function automatic int dsel(input int n); return int'(tx_dest[n*AW +: AW]); endfunction

  // Behavioural reference: 0 idle, 1 asking, 2 responding, 3 linked, 4 refused
  int m_st[N], m_dst[N], m_key[N];
  bit m_free[NK];
  bit m_own[N], m_win[N], taken[NK], back[NK];

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      for (int t = 0; t < N; t++) begin m_st[t] = 0; m_dst[t] = 0; m_key[t] = 0; end
      for (int k = 0; k < NK; k++) m_free[k] = 1;
    end else begin
      for (int r = 0; r < N; r++) begin
        m_own[r] = 0;
        for (int t = 0; t < N; t++)
          if (m_st[t] >= 1 && m_st[t] <= 3 && m_dst[t] == r) m_own[r] = 1;
      end
      for (int t = 0; t < N; t++) m_win[t] = 0;
      for (int r = 0; r < N; r++) begin
        for (int t = 0; t < N; t++) begin
          if ((m_st[t] == 0 || m_st[t] == 4) && tx_req[t] && dsel(t) < N &&
              dsel(t) != t && dsel(t) == r && !m_own[r]) begin
            m_win[t] = 1;
            break;
          end
        end
      end
      for (int k = 0; k < NK; k++) begin taken[k] = 0; back[k] = 0; end
      for (int t = 0; t < N; t++) begin
        case (m_st[t])
          0, 4: begin
            if (!tx_req[t]) m_st[t] = 0;
            else if (dsel(t) >= N || dsel(t) == t) m_st[t] = 4;
            else if (m_win[t]) begin
              m_dst[t] = dsel(t);
              m_st[t]  = rx_dedicated[dsel(t)] ? 2 : 1;
            end
          end
          1: begin
            if (!tx_req[t]) m_st[t] = 0;
            else if (rx_ack[m_dst[t]]) m_st[t] = 2;
            else if (rx_busy[m_dst[t]]) m_st[t] = 4;
          end
          2: begin
            if (!tx_req[t]) m_st[t] = 0;
            else begin
              for (int k = 0; k < NK; k++)
                if (m_free[k] && !taken[k]) begin taken[k] = 1; m_key[t] = k; break; end
              m_st[t] = 3;
            end
          end
          default: if (!tx_req[t]) begin back[m_key[t]] = 1; m_key[t] = 0; m_st[t] = 0; end
        endcase
      end
      for (int k = 0; k < NK; k++) m_free[k] = (m_free[k] && !taken[k]) || back[k];
    end
  end

  // Every-cycle comparison against the reference
  always @(negedge clk) begin
    if (rst_n) begin
      for (int t = 0; t < N; t++) begin
        chk(tx_grant[t] == (m_st[t] == 3), "R3 grant", tx_grant[t], m_st[t] == 3);
        chk(tx_refuse[t] == (m_st[t] == 4), "R4 refuse", tx_refuse[t], m_st[t] == 4);
        chk(tk(t) == ((m_st[t] == 3) ? m_key[t] : 0), "R6 tx_key", tk(t),
            (m_st[t] == 3) ? m_key[t] : 0);
      end
      for (int r = 0; r < N; r++) begin
        int ow;
        ow = -1;
        for (int t = 0; t < N; t++)
          if (m_st[t] >= 1 && m_st[t] <= 3 && m_dst[t] == r) ow = t;
        chk(rx_notify[r] == (ow >= 0 && m_st[ow] == 1), "R2 notify", rx_notify[r],
            ow >= 0 && m_st[ow] == 1);
        chk(rx_link[r] == (ow >= 0 && m_st[ow] == 3), "R8 link", rx_link[r],
            ow >= 0 && m_st[ow] == 3);
        chk(pr(r) == ((ow >= 0) ? ow : 0), "R2 peer", pr(r), (ow >= 0) ? ow : 0);
        chk(rk(r) == ((ow >= 0 && m_st[ow] == 3) ? m_key[ow] : 0), "R6 rx_key", rk(r),
            (ow >= 0 && m_st[ow] == 3) ? m_key[ow] : 0);
      end
    end
  end

  task automatic tick(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic ask(input int t, input int d);
    tx_req[t] = 1'b1;
    tx_dest[t*AW +: AW] = AW'(d);
  endtask

  task automatic quiet();
    tx_req = '0; rx_ack = '0; rx_busy = '0; rx_dedicated = '0;
    tick(3);
  endtask

  initial begin
    tick(3);
    chk(tx_grant == 0 && rx_notify == 0 && rx_link == 0 && tx_refuse == 0, "R1 reset outs",
        int'(tx_grant | rx_notify | rx_link | tx_refuse), 0);
    chk(tx_key == 0 && rx_key == 0 && rx_peer == 0, "R1 reset fields", int'(tx_key | rx_key), 0);
    rst_n = 1'b1;
    tick(1);

    // Pairs 0->1, 2->3, 4->5 with ready receivers
    rx_ack = 6'b101010;
    ask(0, 1); ask(2, 3); ask(4, 5);
    tick(1);
    chk(rx_notify[1] && rx_notify[3] && rx_notify[5], "R2 notify pairs", int'(rx_notify), 42);
    chk(pr(5) == 4, "R2 peer of 5", pr(5), 4);
    tick(1);
    chk(tx_grant == 0, "R3 no grant at 2 edges", int'(tx_grant), 0);
    tick(1);
    chk(tx_grant == 6'b010101, "R3 grant at 3 edges", int'(tx_grant), 21);
    chk(tk(0) == 0 && tk(2) == 1 && tk(4) == 2, "R6 lowest keys in order",
        tk(0) * 100 + tk(2) * 10 + tk(4), 12);
    chk(rk(1) == tk(0) && rk(3) == tk(2) && rk(5) == tk(4), "R6 both ends same key", rk(3), tk(2));

    // Teardown then re-link reuses the returned index
    tx_req[2] = 1'b0;
    tick(1);
    chk(!tx_grant[2] && !rx_link[3] && rk(3) == 0, "R8 teardown", int'(tx_grant[2]), 0);
    ask(2, 3);
    tick(3);
    chk(tx_grant[2] && tk(2) == 1, "R6 index reused", tk(2), 1);
    quiet();

    // Busy receiver
    rx_busy[0] = 1'b1;
    ask(3, 0);
    tick(1);
    chk(rx_notify[0] && pr(0) == 3, "R2 notify busy port", pr(0), 3);
    tick(1);
    chk(tx_refuse[3] && !rx_notify[0], "R4 busy refuses", int'(tx_refuse[3]), 1);
    quiet();

    // Dedicated port, receiver answering busy is never asked
    rx_dedicated[4] = 1'b1; rx_busy[4] = 1'b1;
    ask(5, 4);
    tick(1);
    chk(!tx_grant[5] && !rx_notify[4], "R5 not yet, not asked", int'(tx_grant[5]), 0);
    tick(1);
    chk(tx_grant[5] && rx_link[4] && tk(5) == 0, "R5 grant at 2 edges", int'(tx_grant[5]), 1);
    quiet();

    // Three senders race onto one unanswered receiver
    ask(1, 0); ask(3, 0); ask(5, 0);
    tick(1);
    chk(rx_notify[0] && pr(0) == 1, "R7 lowest index wins", pr(0), 1);
    tick(4);
    chk(rx_notify[0] && pr(0) == 1, "R10 waits for answer", int'(rx_notify[0]), 1);
    chk(tx_refuse == 0 && tx_grant == 0, "R7 losers neither", int'(tx_refuse | tx_grant), 0);
    tx_req[1] = 1'b0;
    tick(1);
    chk(!rx_notify[0], "R10 withdraw releases", int'(rx_notify[0]), 0);
    tick(1);
    chk(rx_notify[0] && pr(0) == 3, "R7 next in line", pr(0), 3);
    quiet();

    // Invalid destinations
    ask(2, 2); ask(4, 7);
    tick(1);
    chk(tx_refuse[2] && tx_refuse[4], "R9 self and out of range", int'(tx_refuse), 20);
    quiet();

    // Random traffic against the reference model
    for (int i = 0; i < 3000; i++) begin
      for (int t = 0; t < N; t++) begin
        if ($urandom_range(0, 7) == 0) tx_req[t] = ~tx_req[t];
        if ($urandom_range(0, 5) == 0) tx_dest[t*AW +: AW] = AW'($urandom_range(0, 7));
        if ($urandom_range(0, 3) == 0) rx_ack[t] = ($urandom_range(0, 2) != 0);
        if ($urandom_range(0, 3) == 0) rx_busy[t] = ($urandom_range(0, 2) == 0);
        if ($urandom_range(0, 30) == 0) rx_dedicated[t] = ~rx_dedicated[t];
      end
      tick(1);
    end
    quiet();

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule